// File: doc/BRIEF.md
# Configuration Space Access Controller

This block sits in front of a device's 4 KB configuration space and serves one request per cycle. Each request carries a dword index, four byte enables, a read/write flag, a path flag (I/O-mapped or memory-mapped) and an upstream flag. The upstream flag marks an I/O or configuration cycle that came in from the downstream link. The block decides whether the access size and path are legal for the addressed region. It then steers the byte lanes in little-endian order, reads or writes a small register array, and returns one completion carrying a status and read data.

Upstream I/O or configuration cycles are never allowed to change state. Each one is turned into a full-dword read of offset 0. That still produces a completion with data, but the completion is marked as an unsupported request. Accesses with an illegal size, an illegal path or misaligned lanes are also refused with unsupported-request status.

The register array holds a few dwords at the bottom of the space and a few at the start of the extended region. Per-register reserved masks keep reserved bits at zero.

Top module: `cfg_access_ctrl`

## Requirements
- R1: In the low region (offsets 0 to 255), byte, word and dword accesses succeed on either path (`req_mem_path` 0 = I/O-mapped, 1 = memory-mapped). `cpl_status` 0 means success.
- R2: The only legal byte-enable patterns are 0001, 0010, 0100 and 1000 (byte), 0011 and 1100 (aligned word), and 1111 (dword). Any other pattern, including 0000, completes with `cpl_status` 1 (unsupported request).
- R3: The configuration-address register is at dword index 2 (offset 0x08). It accepts only byte enables 1111; any partial access to it is unsupported.
- R4: Dword indices 64 to 1023 (offsets 256 to 4095) succeed only on the memory-mapped path with byte enables 1111. An I/O-path access there, or a partial access, is unsupported.
- R5: The lanes are little-endian. Byte enable bit k selects data bits [8k+7:8k], which is byte address 4*index+k. Read data outside the enabled lanes is zero.
- R6: A successful write changes only the byte lanes whose enables are set.
- R7: Some bits are reserved. At dword index 2, bits 30:24 and 1:0 are reserved. At every other implemented odd index, bits 31:28 and 3:0 are reserved. Reserved bits are never written and always read as zero.
- R8: An upstream request, whether read or write, completes as unsupported. Its data is the full dword at index 0, and it writes nothing.
- R9: An unsupported request changes no register. Its completion data is zero, except for upstream requests (see R8).
- R10: Every request produces exactly one completion, with `cpl_valid` high in the cycle after acceptance. No completion appears without a request. Write completions carry zero data.
- R11: The implemented dwords are indices 0 to 7 and 64 to 67. A legal access anywhere else succeeds, reads zero and stores nothing.
- R12: After reset, every register is zero and `cpl_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_dw | input | 10 | Dword index into the 4 KB space |
| req_be | input | 4 | Byte enables, bit k = byte lane k |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem_path | input | 1 | 1 = memory-mapped, 0 = I/O-mapped |
| req_upstream | input | 1 | I/O or configuration cycle from the downstream link |
| req_wdata | input | 32 | Write data, little-endian lanes |
| cpl_valid | output | 1 | Completion present |
| cpl_status | output | 1 | 0 = success, 1 = unsupported request |
| cpl_rdata | output | 32 | Completion read data |

## Verification
Directed cases cover the three regions:
- the low region, with every byte-enable pattern;
- the configuration-address dword, with partial and full accesses;
- the extended region, on both paths.

These cases separate the size rules from the path rule. Single-byte writes of distinct bytes followed by word and dword reads show lane order and lane isolation. All-ones writes to odd and configuration-address dwords expose the reserved masks. Upstream writes followed by reads of index 0 show that re-routing neither writes nor loses data. Seeded random traffic then mixes all flags over implemented and unimplemented indices against a bench model, and idle cycles check for completions that have no request.

// File: rtl/cfg_access_pkg.sv
package cfg_access_pkg;

    typedef enum logic {
        CPL_OK = 1'b0,
        CPL_UR = 1'b1
    } cpl_status_e;

    // legal lane patterns: single byte, aligned word, full dword
    function automatic logic be_shape_ok(input logic [3:0] be);
        case (be)
            4'b0001, 4'b0010, 4'b0100, 4'b1000,
            4'b0011, 4'b1100, 4'b1111: be_shape_ok = 1'b1;
            default:                   be_shape_ok = 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] lane_mask(input logic [3:0] be);
        lane_mask = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    endfunction

    function automatic logic [31:0] rsvd_mask(input int unsigned dw, input int unsigned cfg_dw);
        if (dw == cfg_dw)
            rsvd_mask = 32'h7F00_0003;
        else if (dw % 2 == 1)
            rsvd_mask = 32'hF000_000F;
        else
            rsvd_mask = 32'h0000_0000;
    endfunction

endpackage

// File: rtl/cfg_region_decode.sv
module cfg_region_decode
    import cfg_access_pkg::*;
#(
    parameter int unsigned DW_W      = 10,
    parameter int unsigned LOW_REGS  = 8,
    parameter int unsigned EXT_BASE  = 64,
    parameter int unsigned EXT_REGS  = 4,
    parameter int unsigned CFG_DW    = 2,
    parameter int unsigned SLOT_W    = 4
) (
    input  logic [DW_W-1:0]   dw,
    input  logic [3:0]        be,
    input  logic              mem_path,
    output logic              legal,
    output logic              hit,
    output logic [SLOT_W-1:0] slot
);
    logic in_ext;
    logic in_cfg;
    logic hit_low;
    logic hit_ext;

    always_comb begin
        in_ext  = (dw >= DW_W'(EXT_BASE));
        in_cfg  = (dw == DW_W'(CFG_DW));
        hit_low = (dw < DW_W'(LOW_REGS));
        hit_ext = in_ext && (dw < DW_W'(EXT_BASE + EXT_REGS));
        legal   = be_shape_ok(be);
        if (in_cfg && be != 4'hF) legal = 1'b0;
        if (in_ext && (!mem_path || be != 4'hF)) legal = 1'b0;
        hit  = hit_low || hit_ext;
        slot = '0;
        if (hit_low) slot = SLOT_W'(dw);
        else if (hit_ext) slot = SLOT_W'(dw - DW_W'(EXT_BASE) + DW_W'(LOW_REGS));
    end

endmodule

// File: rtl/cfg_reg_array.sv
module cfg_reg_array
    import cfg_access_pkg::*;
#(
    parameter int unsigned LOW_REGS = 8,
    parameter int unsigned EXT_BASE = 64,
    parameter int unsigned EXT_REGS = 4,
    parameter int unsigned CFG_DW   = 2,
    parameter int unsigned SLOT_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [3:0]        wr_be,
    input  logic [31:0]       wr_data,
    input  logic [SLOT_W-1:0] rd_slot,
    input  logic              rd_hit,
    output logic [31:0]       rd_data
);
    localparam int unsigned NSLOTS = LOW_REGS + EXT_REGS;

    typedef struct packed {
        logic [NSLOTS-1:0][31:0] regs;
    } arr_t;

    arr_t arr_d, arr_q;

    function automatic int unsigned slot_dw(input int unsigned s);
        slot_dw = (s < LOW_REGS) ? s : (EXT_BASE + s - LOW_REGS);
    endfunction

    always_comb begin
        logic [31:0] keep_m;
        arr_d  = arr_q;
        keep_m = lane_mask(wr_be) & ~rsvd_mask(slot_dw(int'(wr_slot)), CFG_DW);
        if (wr_en && int'(wr_slot) < NSLOTS)
            arr_d.regs[wr_slot] = (arr_q.regs[wr_slot] & ~keep_m) | (wr_data & keep_m);
        rd_data = (rd_hit && int'(rd_slot) < NSLOTS) ? arr_q.regs[rd_slot] : 32'h0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) arr_q <= '0;
        else        arr_q <= arr_d;
    end

    // R9: storage moves only on a write strobe
    a_r9_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(arr_q));

    for (genvar g = 0; g < NSLOTS; g++) begin : g_rsvd_chk
        localparam logic [31:0] RM = rsvd_mask(slot_dw(g), CFG_DW);
        // R7: reserved positions stay clear
        a_r7_rsvd_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (arr_q.regs[g] & RM) == 32'h0);
    end

endmodule

// File: rtl/cfg_access_ctrl.sv
module cfg_access_ctrl
    import cfg_access_pkg::*;
#(
    parameter int unsigned SPACE_BYTES = 4096,
    parameter int unsigned LOW_BYTES   = 256,
    parameter int unsigned LOW_REGS    = 8,
    parameter int unsigned EXT_REGS    = 4,
    parameter int unsigned CFG_DW      = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [9:0]  req_dw,
    input  logic [3:0]  req_be,
    input  logic        req_write,
    input  logic        req_mem_path,
    input  logic        req_upstream,
    input  logic [31:0] req_wdata,
    output logic        cpl_valid,
    output logic        cpl_status,
    output logic [31:0] cpl_rdata
);
    localparam int unsigned DW_W     = $clog2(SPACE_BYTES / 4);
    localparam int unsigned EXT_BASE = LOW_BYTES / 4;
    localparam int unsigned SLOT_W   = $clog2(LOW_REGS + EXT_REGS);

    typedef struct packed {
        logic        valid;
        cpl_status_e status;
        logic [31:0] rdata;
    } cpl_t;

    cpl_t cpl_d, cpl_q;

    logic [DW_W-1:0]   eff_dw;
    logic [3:0]        eff_be;
    logic              dec_legal;
    logic              dec_hit;
    logic [SLOT_W-1:0] dec_slot;
    logic              wr_en;
    logic [31:0]       arr_rdata;

    // upstream cycles are rerouted as a full read of offset zero
    assign eff_dw = req_upstream ? '0 : DW_W'(req_dw);
    assign eff_be = req_upstream ? 4'hF : req_be;

    cfg_region_decode #(
        .DW_W(DW_W), .LOW_REGS(LOW_REGS), .EXT_BASE(EXT_BASE),
        .EXT_REGS(EXT_REGS), .CFG_DW(CFG_DW), .SLOT_W(SLOT_W)
    ) i_decode (
        .dw(eff_dw), .be(eff_be), .mem_path(req_mem_path || req_upstream),
        .legal(dec_legal), .hit(dec_hit), .slot(dec_slot)
    );

    assign wr_en = req_valid && !req_upstream && dec_legal && req_write && dec_hit;

    cfg_reg_array #(
        .LOW_REGS(LOW_REGS), .EXT_BASE(EXT_BASE), .EXT_REGS(EXT_REGS),
        .CFG_DW(CFG_DW), .SLOT_W(SLOT_W)
    ) i_array (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_slot(dec_slot), .wr_be(req_be), .wr_data(req_wdata),
        .rd_slot(dec_slot), .rd_hit(dec_hit), .rd_data(arr_rdata)
    );

    always_comb begin
        cpl_d        = '0;
        cpl_d.valid  = req_valid;
        cpl_d.status = CPL_UR;
        if (req_valid) begin
            if (req_upstream) begin
                cpl_d.rdata = arr_rdata;
            end else if (dec_legal) begin
                cpl_d.status = CPL_OK;
                if (!req_write) cpl_d.rdata = arr_rdata & lane_mask(req_be);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cpl_q <= '0;
        else        cpl_q <= cpl_d;
    end

    assign cpl_valid  = cpl_q.valid;
    assign cpl_status = cpl_q.status;
    assign cpl_rdata  = cpl_q.rdata;

    // R10: one completion, one cycle after each request
    a_r10_cpl_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> cpl_valid);
    a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !cpl_valid);
    // R8: upstream cycles always end unsupported
    a_r8_upstream_ur: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_upstream |=> cpl_status == CPL_UR);
    // R4: extended region refused on the I/O path
    a_r4_io_ext_ur: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_upstream && !req_mem_path && req_dw >= 10'(EXT_BASE)
        |=> cpl_status == CPL_UR);
    // R9: refused non-upstream requests return zero data
    a_r9_ur_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_upstream && !dec_legal |=> cpl_rdata == 32'h0);

endmodule

// File: tb/test_cfg_access_ctrl.sv
`timescale 1ns/1ps
module test_cfg_access_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [9:0]  req_dw = '0;
    logic [3:0]  req_be = '0;
    logic        req_write = 1'b0;
    logic        req_mem_path = 1'b0;
    logic        req_upstream = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        cpl_valid;
    logic        cpl_status;
    logic [31:0] cpl_rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [31:0] model [0:1023];
    logic [31:0] got;

    always #2 clk = ~clk;

    cfg_access_ctrl i_cfg_access_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dw(req_dw),
        .req_be(req_be), .req_write(req_write), .req_mem_path(req_mem_path),
        .req_upstream(req_upstream), .req_wdata(req_wdata),
        .cpl_valid(cpl_valid), .cpl_status(cpl_status), .cpl_rdata(cpl_rdata)
    );

    function automatic bit impl(input logic [9:0] dw);
        return (dw < 8) || (dw >= 64 && dw < 68);
    endfunction

    function automatic logic [31:0] rsvd(input logic [9:0] dw);
        if (dw == 2) return 32'h7F00_0003;
        if (dw[0] && impl(dw)) return 32'hF000_000F;
        return 32'h0;
    endfunction

    function automatic logic [31:0] lanes(input logic [3:0] be);
        return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    endfunction

    function automatic bit legal(input logic [9:0] dw, input logic [3:0] be, input logic mp);
        bit ok;
        ok = (be inside {4'h1, 4'h2, 4'h4, 4'h8, 4'h3, 4'hC, 4'hF});
        if (dw == 2 && be != 4'hF) ok = 0;
        if (dw >= 64 && (!mp || be != 4'hF)) ok = 0;
        return ok;
    endfunction

    task automatic check(input bit cond, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input string req, input logic up, input logic wr, input logic mp,
                          input logic [9:0] dw, input logic [3:0] be, input logic [31:0] wd,
                          output logic [31:0] rd);
        logic        exp_st;
        logic [31:0] exp_rd;
        logic [31:0] m;
        if (up) begin
            exp_st = 1; exp_rd = model[0];
        end else if (!legal(dw, be, mp)) begin
            exp_st = 1; exp_rd = 0;
        end else if (wr) begin
            exp_st = 0; exp_rd = 0;
            if (impl(dw)) begin
                m = lanes(be) & ~rsvd(dw);
                model[dw] = (model[dw] & ~m) | (wd & m);
            end
        end else begin
            exp_st = 0;
            exp_rd = impl(dw) ? (model[dw] & lanes(be)) : 32'h0;
        end
        req_valid = 1; req_upstream = up; req_write = wr; req_mem_path = mp;
        req_dw = dw; req_be = be; req_wdata = wd;
        @(negedge clk);
        req_valid = 0;
        rd = cpl_rdata;
        check(cpl_valid === 1'b1, {req, " R10 valid"}, {31'h0, cpl_valid}, 32'h1);
        check(cpl_status === exp_st, {req, " status"}, {31'h0, cpl_status}, {31'h0, exp_st});
        check(cpl_rdata === exp_rd, {req, " data"}, cpl_rdata, exp_rd);
    endtask

    initial begin
        #400000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_C0DE));
        for (int i = 0; i < 1024; i++) model[i] = 32'h0;
        repeat (3) @(negedge clk);
        check(cpl_valid === 1'b0, "R12 reset cpl_valid", {31'h0, cpl_valid}, 32'h0);
        rst_n = 1;
        @(negedge clk);
        check(cpl_valid === 1'b0, "R10 idle no completion", {31'h0, cpl_valid}, 32'h0);
        for (int d = 0; d < 8; d++) access("R12 reset read", 0, 0, 1, 10'(d), 4'hF, 0, got);

        // R5 R6: single bytes land in their own lanes
        access("R5 byte0", 0, 1, 0, 4, 4'h1, 32'h1111_11A0, got);
        access("R5 byte2", 0, 1, 1, 4, 4'h4, 32'h22C2_2222, got);
        access("R6 dword read", 0, 0, 0, 4, 4'hF, 0, got);
        check(got === 32'h00C2_00A0, "R5 lane order", got, 32'h00C2_00A0);
        access("R6 upper word", 0, 1, 0, 4, 4'hC, 32'hBEEF_5555, got);
        access("R5 lower word", 0, 0, 1, 4, 4'h3, 0, got);
        check(got === 32'h0000_00A0, "R6 lower word kept", got, 32'h0000_00A0);
        access("R5 byte3 read", 0, 0, 0, 4, 4'h8, 0, got);
        check(got === 32'hBE00_0000, "R5 byte3 lane", got, 32'hBE00_0000);

        // R1: all sizes on both paths in low region
        access("R1 io byte", 0, 1, 0, 6, 4'h2, 32'h0000_7700, got);
        access("R1 mem word", 0, 1, 1, 6, 4'h3, 32'h0000_1234, got);
        access("R1 io dword", 0, 0, 0, 6, 4'hF, 0, got);

        // R2: illegal lane shapes
        access("R2 misaligned word", 0, 1, 1, 0, 4'h6, 32'hFFFF_FFFF, got);
        access("R2 three bytes", 0, 1, 0, 0, 4'h7, 32'hFFFF_FFFF, got);
        access("R2 empty", 0, 0, 1, 0, 4'h0, 0, got);
        access("R9 unchanged", 0, 0, 1, 0, 4'hF, 0, got);
        check(got === 32'h0, "R9 no write on UR", got, 32'h0);

        // R3 R7: configuration address register
        access("R3 partial write", 0, 1, 0, 2, 4'h1, 32'hFFFF_FFFF, got);
        access("R3 full write", 0, 1, 0, 2, 4'hF, 32'hFFFF_FFFF, got);
        access("R7 cfg read", 0, 0, 1, 2, 4'hF, 0, got);
        check(got === 32'h80FF_FFFC, "R7 cfg reserved zero", got, 32'h80FF_FFFC);
        access("R7 odd write", 0, 1, 1, 5, 4'hF, 32'hFFFF_FFFF, got);
        access("R7 odd read", 0, 0, 1, 5, 4'hF, 0, got);
        check(got === 32'h0FFF_FFF0, "R7 odd reserved zero", got, 32'h0FFF_FFF0);

        // R4: extended region
        access("R4 mem dword write", 0, 1, 1, 65, 4'hF, 32'h1234_5678, got);
        access("R4 io dword write", 0, 1, 0, 65, 4'hF, 32'hFFFF_FFFF, got);
        access("R4 mem byte write", 0, 1, 1, 64, 4'h1, 32'hFF, got);
        access("R4 io read", 0, 0, 0, 65, 4'hF, 0, got);
        access("R4 mem read", 0, 0, 1, 65, 4'hF, 0, got);
        check(got === 32'h0234_5670, "R4 stored ext", got, 32'h0234_5670);

        // R11: unimplemented but legal
        access("R11 write", 0, 1, 1, 30, 4'hF, 32'hDEAD_BEEF, got);
        access("R11 read", 0, 0, 1, 30, 4'hF, 0, got);
        access("R11 ext write", 0, 1, 1, 900, 4'hF, 32'hDEAD_BEEF, got);
        access("R11 ext read", 0, 0, 1, 900, 4'hF, 0, got);

        // R8: upstream reroute
        access("R8 seed idx0", 0, 1, 1, 0, 4'hF, 32'hCAFE_F00D, got);
        access("R8 upstream write", 1, 1, 0, 7, 4'h1, 32'h0000_0000, got);
        check(got === 32'hCAFE_F00D, "R8 data from index 0", got, 32'hCAFE_F00D);
        access("R8 upstream read", 1, 0, 1, 70, 4'h6, 0, got);
        access("R8 idx7 untouched", 0, 0, 1, 7, 4'hF, 0, got);

        // random traffic with back-to-back and idle gaps
        for (int n = 0; n < 600; n++) begin
            logic [9:0] dw;
            logic [3:0] be;
            int sel;
            sel = $urandom_range(0, 3);
            if (sel == 0) dw = 10'($urandom_range(0, 9));
            else if (sel == 1) dw = 10'($urandom_range(62, 69));
            else if (sel == 2) dw = 10'($urandom_range(0, 1023));
            else dw = 10'($urandom_range(0, 7));
            be = ($urandom_range(0, 2) == 0) ? 4'hF : 4'($urandom);
            access("R1 R10 random", ($urandom_range(0, 15) == 0), 1'($urandom),
                   1'($urandom), dw, be, $urandom, got);
            if ($urandom_range(0, 7) == 0) begin
                @(negedge clk);
                check(cpl_valid === 1'b0, "R10 idle gap", {31'h0, cpl_valid}, 32'h0);
            end
        end
        for (int d = 0; d < 70; d++)
            if (impl(10'(d))) access("R6 final sweep", 0, 0, 1, 10'(d), 4'hF, 0, got);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule